// File: doc/BRIEF.md
# Preemptive Priority Scheduling Decision Unit

This unit decides, each time the state of some task changes, whether the processor should give up the running task for another one. The task manager pulses a schedule request whenever it creates, deletes, suspends or resumes a task. Alongside that pulse it supplies three more inputs. The first is the best priority currently marked ready, with a valid flag. The second says whether the running task is still ready. The third pair are two blocking conditions: the task manager is busy, or an interrupt service routine is active. A request that arrives while either blocking condition holds is kept in a pending flag. The unit evaluates it in the first cycle when both conditions are clear.

The unit holds the identity of the running task itself. It reports a switch with a one-cycle pulse, and on that same cycle the new task ID appears on the next-task output and in the running-task register. A request does not always cause a switch. The unit switches only when it has no running task, when the running task has left the ready set, or when the ready candidate is strictly better. By default a lower number means a higher priority. A separate clear input discards any held request.

Top module: `sched_decide`

## Requirements
- R1: After reset, sw_pulse is 0, run_valid is 0, and run_id and next_id are both 0.
- R2: An evaluation happens only in a cycle where busy and in_isr are both 0. A request that arrives while either is 1 is held, and it is evaluated in the first cycle in which both are 0. No switch pulse appears while the request is blocked.
- R3: pend_clr discards a held request and suppresses evaluation in the cycle in which it is 1. After that, no switch results from the discarded request.
- R4: When there is no running task (run_valid 0), an evaluation with hi_valid 1 switches to hi_prio.
- R5: With the running task still ready (cur_ready 1), an evaluation switches only if hi_prio is strictly better than run_id. With the default LOW_WINS=1, better means numerically smaller. An equal or worse candidate leaves sw_pulse 0 and run_id and next_id unchanged.
- R6: When cur_ready is 0 and hi_valid is 1, an evaluation switches to hi_prio whatever the comparison gives.
- R7: When cur_ready is 0 and hi_valid is 0, an evaluation clears run_valid and produces no pulse.
- R8: A switch decided at clock edge k drives sw_pulse high for exactly the cycle that follows edge k. next_id and run_id show the new task from that same cycle onward, and run_valid is 1.
- R9: With the running task ready and hi_valid 0, an evaluation changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sched_req | input | 1 | Pulse: task state changed, evaluate |
| hi_prio | input | PW | Best priority in the ready set |
| hi_valid | input | 1 | Ready set is not empty |
| cur_ready | input | 1 | Running task is still in the ready set |
| busy | input | 1 | Task manager is mid-operation |
| in_isr | input | 1 | Interrupt service active |
| pend_clr | input | 1 | Discard a held request |
| sw_pulse | output | 1 | One-cycle switch request |
| next_id | output | PW | Task selected by the latest switch |
| run_id | output | PW | Running-task register |
| run_valid | output | 1 | A running task exists |

## Verification
The bench builds the unit with its defaults: PW=6, which gives 64 task priorities, and LOW_WINS=1. With these values it can replay the create, suspend, resume and delete orderings with task numbers 1 to 7, and it can also reach priority 0 and priority 63 at the edges of the range. Because the bench derives the best ready priority from its own 64-bit ready mask, the unit sees the same hi_prio sequence that a real ready list would produce. A blocked request is held through several busy cycles and several interrupt cycles, so the test shows that release happens exactly one edge after the last blocking cycle.

// File: rtl/sched_pkg.sv
package sched_pkg;

  localparam int WIDE = 16;

  typedef enum logic [1:0] {
    DEC_NONE   = 2'd0,
    DEC_SWITCH = 2'd1,
    DEC_DROP   = 2'd2
  } dec_e;

  // True when cand is strictly better than cur under the given polarity.
  function automatic logic prio_beats(input logic [WIDE-1:0] cand,
                                      input logic [WIDE-1:0] cur,
                                      input logic            low_wins);
    if (low_wins) return cand < cur;
    return cand > cur;
  endfunction

  // Decision from the comparison and the state flags.
  function automatic dec_e pick(input logic hv, input logic rv,
                                input logic cr, input logic better);
    if (!rv)   return hv ? DEC_SWITCH : DEC_NONE;
    if (!cr)   return hv ? DEC_SWITCH : DEC_DROP;
    if (hv && better) return DEC_SWITCH;
    return DEC_NONE;
  endfunction

endpackage

// File: rtl/sched_gate.sv
module sched_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic sched_req,
  input  logic busy,
  input  logic in_isr,
  input  logic pend_clr,
  output logic eval_go,
  output logic pend_q
);
  logic gate_open;
  logic want;

  assign gate_open = !busy && !in_isr;
  assign want      = sched_req || pend_q;
  assign eval_go   = want && gate_open && !pend_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pend_q <= 1'b0;
    else if (pend_clr)   pend_q <= 1'b0;
    else if (eval_go)    pend_q <= 1'b0;
    else if (sched_req)  pend_q <= 1'b1;
  end
endmodule

// File: rtl/sched_cmp.sv
module sched_cmp #(
  parameter int PW       = 6,
  parameter bit LOW_WINS = 1'b1
) (
  input  logic [PW-1:0]      hi_prio,
  input  logic               hi_valid,
  input  logic [PW-1:0]      run_id,
  input  logic               run_valid,
  input  logic               cur_ready,
  output sched_pkg::dec_e    dec,
  output logic               better
);
  generate
    if (LOW_WINS) begin : g_low
      assign better = hi_prio < run_id;
    end else begin : g_high
      assign better = hi_prio > run_id;
    end
  endgenerate

  always_comb begin
    dec = sched_pkg::pick(hi_valid, run_valid, cur_ready, better);
  end
endmodule

// File: rtl/sched_run.sv
module sched_run #(
  parameter int PW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            eval_go,
  input  sched_pkg::dec_e dec,
  input  logic [PW-1:0]   hi_prio,
  output logic            sw_pulse,
  output logic [PW-1:0]   next_id,
  output logic [PW-1:0]   run_id,
  output logic            run_valid
);
  logic do_switch;
  logic do_drop;

  assign do_switch = eval_go && (dec == sched_pkg::DEC_SWITCH);
  assign do_drop   = eval_go && (dec == sched_pkg::DEC_DROP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_pulse  <= 1'b0;
      next_id   <= '0;
      run_id    <= '0;
      run_valid <= 1'b0;
    end else begin
      sw_pulse <= do_switch;
      if (do_switch) begin
        next_id   <= hi_prio;
        run_id    <= hi_prio;
        run_valid <= 1'b1;
      end else if (do_drop) begin
        run_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sched_decide.sv
module sched_decide #(
  parameter int PW       = 6,
  parameter bit LOW_WINS = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sched_req,
  input  logic [PW-1:0] hi_prio,
  input  logic          hi_valid,
  input  logic          cur_ready,
  input  logic          busy,
  input  logic          in_isr,
  input  logic          pend_clr,
  output logic          sw_pulse,
  output logic [PW-1:0] next_id,
  output logic [PW-1:0] run_id,
  output logic          run_valid
);
  logic            eval_go;
  logic            pend_q;
  logic            better;
  sched_pkg::dec_e dec;

  sched_gate u_gate (
    .clk(clk), .rst_n(rst_n), .sched_req(sched_req), .busy(busy),
    .in_isr(in_isr), .pend_clr(pend_clr), .eval_go(eval_go), .pend_q(pend_q)
  );

  sched_cmp #(.PW(PW), .LOW_WINS(LOW_WINS)) u_cmp (
    .hi_prio(hi_prio), .hi_valid(hi_valid), .run_id(run_id),
    .run_valid(run_valid), .cur_ready(cur_ready), .dec(dec), .better(better)
  );

  sched_run #(.PW(PW)) u_run (
    .clk(clk), .rst_n(rst_n), .eval_go(eval_go), .dec(dec), .hi_prio(hi_prio),
    .sw_pulse(sw_pulse), .next_id(next_id), .run_id(run_id), .run_valid(run_valid)
  );
endmodule

// File: rtl/sched_decide_chk.sv
module sched_decide_chk #(
  parameter int PW       = 6,
  parameter bit LOW_WINS = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sched_req,
  input logic [PW-1:0] hi_prio,
  input logic          hi_valid,
  input logic          cur_ready,
  input logic          busy,
  input logic          in_isr,
  input logic          pend_clr,
  input logic          sw_pulse,
  input logic [PW-1:0] next_id,
  input logic [PW-1:0] run_id,
  input logic          run_valid,
  input logic          eval_go,
  input logic          pend_q
);
  a_r2_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
    eval_go |-> (!busy && !in_isr));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sched_req && (busy || in_isr) && !pend_clr) |=> pend_q);

  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    pend_clr |=> !pend_q);

  a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
    sw_pulse |-> (run_id == next_id && run_valid));

  a_r8_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_go |=> (!sw_pulse && $stable(run_id)));

  a_r5_no_worse: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_go && run_valid && cur_ready &&
     !sched_pkg::prio_beats(16'(hi_prio), 16'(run_id), LOW_WINS)) |=> !sw_pulse);
endmodule

bind sched_decide sched_decide_chk #(.PW(PW), .LOW_WINS(LOW_WINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sched_req(sched_req), .hi_prio(hi_prio),
  .hi_valid(hi_valid), .cur_ready(cur_ready), .busy(busy), .in_isr(in_isr),
  .pend_clr(pend_clr), .sw_pulse(sw_pulse), .next_id(next_id), .run_id(run_id),
  .run_valid(run_valid), .eval_go(eval_go), .pend_q(pend_q)
);

// File: tb/tb_sched_decide.sv
`timescale 1ns/1ps
module tb_sched_decide;
  localparam int PW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sched_req = 1'b0;
  logic [PW-1:0] hi_prio = '0;
  logic hi_valid = 1'b0;
  logic cur_ready = 1'b0;
  logic busy = 1'b0;
  logic in_isr = 1'b0;
  logic pend_clr = 1'b0;
  logic sw_pulse;
  logic [PW-1:0] next_id;
  logic [PW-1:0] run_id;
  logic run_valid;

  int total = 0;
  int bad = 0;
  logic [63:0] rdy = '0;

  always #2.5 clk = ~clk;

  sched_decide #(.PW(PW)) dut (
    .clk(clk), .rst_n(rst_n), .sched_req(sched_req), .hi_prio(hi_prio),
    .hi_valid(hi_valid), .cur_ready(cur_ready), .busy(busy), .in_isr(in_isr),
    .pend_clr(pend_clr), .sw_pulse(sw_pulse), .next_id(next_id),
    .run_id(run_id), .run_valid(run_valid)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Best ready priority, smaller number wins.
  function automatic int best(input logic [63:0] m);
    for (int i = 0; i < 64; i++) if (m[i]) return i;
    return -1;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; sched_req = 0; busy = 0; in_isr = 0; pend_clr = 0;
    rdy = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Request with inputs from the ready mask; check outputs one edge later.
  task automatic sched(input string tag, input int running, input bit exp_sw,
                       input int exp_run, input bit exp_rv);
    int b;
    b = best(rdy);
    hi_valid  = (b >= 0);
    hi_prio   = (b >= 0) ? PW'(b) : '0;
    cur_ready = (running >= 0) ? rdy[running] : 1'b0;
    sched_req = 1'b1;
    @(negedge clk);
    sched_req = 1'b0;
    check({tag, " pulse"}, int'(sw_pulse), int'(exp_sw));
    check({tag, " run_id"}, int'(run_id), exp_run);
    check({tag, " run_valid"}, int'(run_valid), int'(exp_rv));
    if (exp_sw) check({tag, " next_id"}, int'(next_id), exp_run);
    @(negedge clk);
    check({tag, " pulse one cycle R8"}, int'(sw_pulse), 0);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 sw_pulse", int'(sw_pulse), 0);
    check("R1 run_valid", int'(run_valid), 0);
    check("R1 run_id", int'(run_id), 0);
    check("R1 next_id", int'(next_id), 0);
  endtask

  task automatic t_create_seq();
    do_reset();
    rdy[7] = 1; sched("R4 create 7", -1, 1, 7, 1);
    rdy[1] = 1; sched("R5 create 1", 7, 1, 1, 1);
    rdy[6] = 1; sched("R5 create 6 no switch", 1, 0, 1, 1);
    check("R5 next_id kept", int'(next_id), 1);
    sched("R5 equal prio", 1, 0, 1, 1);
    rdy[1] = 0; sched("R6 suspend 1", 1, 1, 6, 1);
    rdy[1] = 1; sched("R5 resume 1", 6, 1, 1, 1);
  endtask

  task automatic t_delete();
    do_reset();
    rdy[5] = 1; sched("R4 create 5", -1, 1, 5, 1);
    rdy[2] = 1; sched("R5 create 2", 5, 1, 2, 1);
    rdy[4] = 1; sched("R5 create 4", 2, 0, 2, 1);
    rdy[2] = 0; sched("R6 delete 2", 2, 1, 4, 1);
    rdy = '0;   sched("R7 none ready", 4, 0, 4, 0);
  endtask

  task automatic t_edges();
    do_reset();
    rdy[63] = 1; sched("R4 prio 63", -1, 1, 63, 1);
    rdy[0] = 1;  sched("R5 prio 0", 63, 1, 0, 1);
    // R9: running ready, ready set reported empty
    hi_valid = 0; cur_ready = 1; sched_req = 1;
    @(negedge clk); sched_req = 0;
    check("R9 no pulse", int'(sw_pulse), 0);
    check("R9 run_id", int'(run_id), 0);
    check("R9 run_valid", int'(run_valid), 1);
  endtask

  task automatic t_blocked(input bit use_isr);
    do_reset();
    rdy[3] = 1; hi_valid = 1; hi_prio = 3; cur_ready = 0;
    if (use_isr) in_isr = 1; else busy = 1;
    sched_req = 1; @(negedge clk); sched_req = 0;
    for (int i = 0; i < 3; i++) begin
      check("R2 blocked no pulse", int'(sw_pulse), 0);
      check("R2 blocked run_valid", int'(run_valid), 0);
      @(negedge clk);
    end
    busy = 0; in_isr = 0;
    @(negedge clk);
    check("R2 released pulse", int'(sw_pulse), 1);
    check("R2 released run_id", int'(run_id), 3);
    @(negedge clk);
    check("R2 pulse once", int'(sw_pulse), 0);
  endtask

  task automatic t_clear();
    do_reset();
    hi_valid = 1; hi_prio = 9; cur_ready = 0;
    busy = 1; sched_req = 1; @(negedge clk); sched_req = 0;
    pend_clr = 1; @(negedge clk); pend_clr = 0;
    busy = 0;
    repeat (3) begin
      @(negedge clk);
      check("R3 discarded no pulse", int'(sw_pulse), 0);
    end
    check("R3 run_valid", int'(run_valid), 0);
    // clear with gate open suppresses same-cycle evaluation
    pend_clr = 1; sched_req = 1; @(negedge clk); sched_req = 0; pend_clr = 0;
    check("R3 same cycle no pulse", int'(sw_pulse), 0);
    @(negedge clk);
    check("R3 still none", int'(sw_pulse), 0);
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_create_seq();
    t_delete();
    t_edges();
    t_blocked(1'b0);
    t_blocked(1'b1);
    t_clear();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule